// File: doc/BRIEF.md
# Strobed Split-Address Bit RAM

This block is a 64-bit storage array, organised as eight rows of eight one-bit cells, that is addressed through a narrow shared address bus. Only three address pins exist. The upper half of the 6-bit cell address, the row, is placed on the bus first and captured by a row strobe. The lower half, the column, follows on the same pins and is captured by a column strobe. A one-hot row decoder selects one stored row. The whole row is fed to a column multiplexer that picks one bit for the read port. On a write, a column demultiplexer steers the single input bit to one cell of the selected row.

The data pin is modelled as a plain input, a plain output and an output-enable, which together stand for a bidirectional pin. Chip select and write are active low. Both strobes are active-high pulses sampled on the rising clock edge. The read path is combinational from the latched address, so there is no valid/ready handshake. Data is valid while the output-enable is high, and the block never applies back-pressure.

Top module: `mux_addr_ram`

## Requirements
- R1: The cell address is 6 bits. The row half (address bits 5..3) arrives first on the 3-bit bus `addr_i`, and the column half (bits 2..0) arrives second on the same bus. Cell (row r, column c) is independent of every other cell.
- R2: Exactly one of the eight internal row selects is active in every cycle, namely the one for the latched row.
- R3: When `row_stb_i` is 1 at a rising edge, `addr_i` becomes the latched row and any captured column becomes invalid. From the next cycle, `doe_o` stays 0 until a column strobe is taken.
- R4: When `col_stb_i` is 1 and `row_stb_i` is 0 at a rising edge, `addr_i` becomes the latched column and the column becomes valid. If both strobes are 1 in the same cycle, the row is taken and the column strobe is ignored. Several column strobes may follow one row strobe.
- R5: `doe_o` is 1 exactly when `cs_ni`=0, `we_ni`=1 and a valid column is held. `dout_o` then shows the stored bit at the latched row and column in the same cycle.
- R6: At a rising edge with `cs_ni`=0, `we_ni`=0 and a valid column held, the cell at the latched row and column takes `din_i`. No other cell changes.
- R7: A write attempt with `cs_ni`=1, or with no valid column held (after a row strobe and before the next column strobe), changes no cell.
- R8: `dout_o` is 0 whenever `doe_o` is 0.
- R9: After reset, every cell reads 0, the latched row and column are 0 and the column is invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Shared address bus carrying the row half, then the column half |
| row_stb_i | input | 1 | Row strobe, active high, single cycle |
| col_stb_i | input | 1 | Column strobe, active high, single cycle |
| cs_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write, active low |
| din_i | input | 1 | Write data bit |
| dout_o | output | 1 | Read data bit, 0 while not driven |
| doe_o | output | 1 | Output enable of the modelled bidirectional data pin |

## Verification
The hardest states to reach from the ports are those where the latched column is stale. One case is a write attempted right after a row strobe, while the column strobed for an earlier row is still held but no longer valid. The other is a row strobe and a column strobe that arrive in the same cycle. Directed tasks first read a known cell, so that the stale column points at something observable. They then issue the new row strobe, attempt the write, or issue both strobes together. Finally they strobe the column and read back, which shows that nothing was written and that the row, not the column, took the address.

// File: rtl/mram_pkg.sv
package mram_pkg;
  typedef enum logic [1:0] {
    STB_NONE = 2'd0,
    STB_ROW  = 2'd1,
    STB_COL  = 2'd2
  } strobe_e;

  // Row strobe has priority over a column strobe in the same cycle
  function automatic strobe_e classify(input logic row_stb, input logic col_stb);
    if (row_stb)      return STB_ROW;
    else if (col_stb) return STB_COL;
    else              return STB_NONE;
  endfunction
endpackage

// File: rtl/mram_addr_latch.sv
module mram_addr_latch
  import mram_pkg::*;
#(
  parameter int HALF_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] addr_i,
  input  logic              row_stb_i,
  input  logic              col_stb_i,
  output logic [HALF_W-1:0] row_o,
  output logic [HALF_W-1:0] col_o,
  output logic              col_vld_o
);
  strobe_e kind;

  always_comb kind = classify(row_stb_i, col_stb_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o     <= '0;
      col_o     <= '0;
      col_vld_o <= 1'b0;
    end else begin
      case (kind)
        STB_ROW: begin
          row_o     <= addr_i;
          col_vld_o <= 1'b0;
        end
        STB_COL: begin
          col_o     <= addr_i;
          col_vld_o <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mram_decoder.sv
module mram_decoder #(
  parameter int W = 3,
  localparam int N = 1 << W
) (
  input  logic [W-1:0] code_i,
  input  logic         en_i,
  output logic [N-1:0] sel_o
);
  always_comb begin
    sel_o         = '0;
    sel_o[code_i] = en_i;
  end
endmodule

// File: rtl/mram_cell_row.sv
module mram_cell_row #(
  parameter int COLS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            row_hit_i,
  input  logic [COLS-1:0] col_wr_i,
  input  logic            din_i,
  output logic [COLS-1:0] bits_o
);
  for (genvar c = 0; c < COLS; c++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       bits_o[c] <= 1'b0;
      else if (row_hit_i && col_wr_i[c]) bits_o[c] <= din_i;
    end
  end
endmodule

// File: rtl/mram_col_mux.sv
module mram_col_mux #(
  parameter int W = 3,
  localparam int N = 1 << W
) (
  input  logic [N-1:0] row_bits_i,
  input  logic [W-1:0] col_i,
  output logic         bit_o
);
  always_comb bit_o = row_bits_i[col_i];
endmodule

// File: rtl/mux_addr_ram.sv
module mux_addr_ram #(
  parameter int HALF_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] addr_i,
  input  logic              row_stb_i,
  input  logic              col_stb_i,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              din_i,
  output logic              dout_o,
  output logic              doe_o
);
  localparam int NROW = 1 << HALF_W;
  localparam int NCOL = 1 << HALF_W;

  logic [HALF_W-1:0] row_q, col_q;
  logic              col_vld;
  logic              wr_fire, rd_ok, picked;
  logic [NROW-1:0]   row_sel;
  logic [NCOL-1:0]   col_wr;
  logic [NCOL-1:0]   row_data [NROW];
  logic [NCOL-1:0]   row_bus;

  mram_addr_latch #(.HALF_W(HALF_W)) latch_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .row_stb_i (row_stb_i),
    .col_stb_i (col_stb_i),
    .row_o     (row_q),
    .col_o     (col_q),
    .col_vld_o (col_vld)
  );

  assign wr_fire = !cs_ni && !we_ni && col_vld;
  assign rd_ok   = !cs_ni &&  we_ni && col_vld;

  mram_decoder #(.W(HALF_W)) row_dec_i (
    .code_i (row_q),
    .en_i   (1'b1),
    .sel_o  (row_sel)
  );

  // Column demultiplexer: one-hot write steer, empty when no write fires
  mram_decoder #(.W(HALF_W)) col_dec_i (
    .code_i (col_q),
    .en_i   (wr_fire),
    .sel_o  (col_wr)
  );

  for (genvar r = 0; r < NROW; r++) begin : g_row
    mram_cell_row #(.COLS(NCOL)) row_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .row_hit_i (row_sel[r]),
      .col_wr_i  (col_wr),
      .din_i     (din_i),
      .bits_o    (row_data[r])
    );
  end

  // AND-OR row bus: the selected row drives the column multiplexer
  always_comb begin
    row_bus = '0;
    for (int r = 0; r < NROW; r++) begin
      row_bus = row_bus | (row_data[r] & {NCOL{row_sel[r]}});
    end
  end

  mram_col_mux #(.W(HALF_W)) col_mux_i (
    .row_bits_i (row_bus),
    .col_i      (col_q),
    .bit_o      (picked)
  );

  assign doe_o  = rd_ok;
  assign dout_o = rd_ok & picked;
endmodule

// File: rtl/mux_addr_ram_chk.sv
module mux_addr_ram_chk #(
  parameter int HALF_W = 3,
  localparam int NROW = 1 << HALF_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            row_stb_i,
  input logic            col_stb_i,
  input logic            cs_ni,
  input logic            we_ni,
  input logic            dout_o,
  input logic            doe_o,
  input logic [NROW-1:0] row_sel
);
  assert_row_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(row_sel) == 1);

  assert_row_kills_col_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_stb_i |=> !doe_o);

  assert_col_opens_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_stb_i && !row_stb_i) |=> (cs_ni || !we_ni || doe_o));

  assert_read_steady_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (doe_o && we_ni && !row_stb_i && !col_stb_i) |=> (!doe_o || $stable(dout_o)));

  assert_quiet_out_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !doe_o |-> !dout_o);
endmodule

bind mux_addr_ram mux_addr_ram_chk #(.HALF_W(HALF_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .row_stb_i (row_stb_i),
  .col_stb_i (col_stb_i),
  .cs_ni     (cs_ni),
  .we_ni     (we_ni),
  .dout_o    (dout_o),
  .doe_o     (doe_o),
  .row_sel   (row_sel)
);

// File: tb/mux_addr_ram_tb_top.sv
module mux_addr_ram_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       row_stb = 1'b0, col_stb = 1'b0;
  logic       cs_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic       dout, doe;
  logic       model_q [64];
  int         total = 0, bad = 0;

  always #10 clk = ~clk;

  mux_addr_ram dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .row_stb_i(row_stb),
    .col_stb_i(col_stb), .cs_ni(cs_n), .we_ni(we_n), .din_i(din),
    .dout_o(dout), .doe_o(doe)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic pulse_row(input int r);
    @(negedge clk); addr = 3'(r); row_stb = 1'b1;
    @(negedge clk); row_stb = 1'b0;
  endtask

  task automatic pulse_col(input int c);
    @(negedge clk); addr = 3'(c); col_stb = 1'b1;
    @(negedge clk); col_stb = 1'b0;
  endtask

  task automatic write_cell(input int r, input int c, input logic d);
    pulse_row(r); pulse_col(c);
    cs_n = 1'b0; we_n = 1'b0; din = d;
    @(negedge clk); cs_n = 1'b1; we_n = 1'b1;
    model_q[r*8+c] = d;
  endtask

  task automatic read_check(input int r, input int c, input string tag);
    pulse_row(r); pulse_col(c);
    cs_n = 1'b0; we_n = 1'b1; #2;
    chk({tag, " doe"}, 32'(doe), 1);
    chk({tag, " data"}, 32'(dout), 32'(model_q[r*8+c]));
    cs_n = 1'b1;
  endtask

  task automatic t_reset;
    cs_n = 1'b0; we_n = 1'b1; #2;
    chk("R9 doe low after reset", 32'(doe), 0);
    chk("R8 dout low when undriven", 32'(dout), 0);
    pulse_col(0); #2;   // row latch was cleared to 0 by reset
    chk("R9 cell 0 via reset row", 32'(doe), 1);
    chk("R9 cell 0 value", 32'(dout), 0);
    cs_n = 1'b1;
    for (int a = 0; a < 64; a++) read_check(a / 8, a % 8, "R9 all zero");
  endtask

  task automatic t_walk;
    write_cell(5, 3, 1'b1);
    for (int a = 0; a < 64; a++) read_check(a / 8, a % 8, "R6 R2 single cell");
    write_cell(5, 3, 1'b0);
  endtask

  task automatic t_nocs;
    write_cell(3, 4, 1'b0);
    pulse_row(3); pulse_col(4);
    cs_n = 1'b1; we_n = 1'b0; din = 1'b1; #2;
    chk("R5 no drive without select", 32'(doe), 0);
    @(negedge clk); we_n = 1'b1;
    read_check(3, 4, "R7 deselected write");
  endtask

  task automatic t_nocol;
    write_cell(2, 6, 1'b0);
    read_check(2, 6, "R7 setup");
    pulse_row(2);
    cs_n = 1'b0; we_n = 1'b1; #2;
    chk("R3 column invalid after row", 32'(doe), 0);
    we_n = 1'b0; din = 1'b1;
    @(negedge clk); cs_n = 1'b1; we_n = 1'b1;
    pulse_col(6);
    cs_n = 1'b0; #2;
    chk("R7 stale column write", 32'(dout), 0);
    cs_n = 1'b1;
  endtask

  task automatic t_both;
    write_cell(4, 1, 1'b1);
    write_cell(1, 1, 1'b0);
    pulse_row(1); pulse_col(1);
    @(negedge clk); addr = 3'd4; row_stb = 1'b1; col_stb = 1'b1;
    @(negedge clk); row_stb = 1'b0; col_stb = 1'b0;
    cs_n = 1'b0; we_n = 1'b1; #2;
    chk("R4 same-cycle strobes keep column invalid", 32'(doe), 0);
    cs_n = 1'b1;
    pulse_col(1);
    cs_n = 1'b0; #2;
    chk("R4 row taken from shared cycle", 32'(dout), 1);
    we_n = 1'b0; #2;
    chk("R5 no drive while writing", 32'(doe), 0);
    cs_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic t_page;
    for (int c = 0; c < 8; c++) write_cell(7, c, 1'((8'hA5 >> c) & 1));
    pulse_row(7);
    for (int c = 0; c < 8; c++) begin
      pulse_col(c);
      cs_n = 1'b0; #2;
      chk("R4 page read", 32'(dout), 32'(model_q[56+c]));
      cs_n = 1'b1;
    end
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      int a = int'($urandom % 64);
      if ($urandom % 2) write_cell(a / 8, a % 8, 1'($urandom % 2));
      else read_check(a / 8, a % 8, "R1 R5 random");
    end
    for (int a = 0; a < 64; a++) read_check(a / 8, a % 8, "R1 final sweep");
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog expired got=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 64; a++) model_q[a] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_walk();
    t_nocs();
    t_nocol();
    t_both();
    t_page();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule